// File: doc/BRIEF.md
# Parallel EPROM Read Controller

This block lets a synchronous host read 16-bit words from an asynchronous UV-erasable or one-time-programmable EPROM with an 18-bit word address. The host offers an address on a valid/ready request port. The controller then drives the address bus, pulls the active-low chip-select strobe low, waits, and pulls the active-low output-gate strobe low. It captures the data word once every access window has elapsed, raises the output gate, and returns the word with a one-cycle response pulse.

Three access windows are set in nanoseconds: address-to-data, select-to-data and gate-to-data. A fourth parameter sets the time the device takes to float its outputs. Each is converted to clock cycles by rounding up. The output gate is held back so that gate-to-data ends exactly when the longer of the address and select windows ends. After every read the controller leaves the bus quiet for the float time before it accepts the next request. If no request arrives for a set number of idle cycles, the controller raises the chip select so that the device drops into low-power standby.

Back-pressure rules: a request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the controller is idle. A request that is offered while `req_ready` is low is neither stored nor acted on; the host must hold it until `req_ready` rises. The response side has no ready input: `rsp_valid` is high for exactly one cycle, and the host must take `rsp_data` in that cycle.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `mem_ce_n` and `mem_oe_n` are 1, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request offered while `req_ready` is 0 is ignored: `mem_addr` does not change and the word returned is that of the read already in progress.
- R3: `mem_oe_n` is low only while `mem_ce_n` is low.
- R4: With default parameters (10 ns clock; 70/70/35/30 ns), `mem_oe_n` falls 3 clock edges after the accepting edge: the longer of the address and select windows (7 cycles) minus the gate window (4 cycles).
- R5: The data word is sampled at the edge 7 cycles after the accepting edge. At that same edge `mem_oe_n` returns high and `rsp_valid` goes high for exactly one cycle, carrying the sampled word.
- R6: `mem_addr` takes the request address at the accepting edge and holds it at least until the sampling edge.
- R7: After `mem_oe_n` rises, `req_ready` stays low for the float time (3 cycles by default). It returns high at that edge.
- R8: After 4 consecutive idle cycles with `mem_ce_n` low and no request, `mem_ce_n` rises (standby). It rises only while the controller is idle.
- R9: A request accepted while in standby pulls `mem_ce_n` low at the accepting edge, and the read has the same timing as in R4 to R7.
- R10: A request offered in the first idle cycle after a read is accepted at once. `mem_ce_n` stays low between the two reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host offers a read address |
| req_ready | output | 1 | Controller is idle and will take a request |
| req_addr | input | 18 | Word address of the request |
| rsp_valid | output | 1 | One-cycle pulse: `rsp_data` holds the read word |
| rsp_data | output | 16 | Word captured from the device |
| mem_addr | output | 18 | Address bus to the EPROM |
| mem_ce_n | output | 1 | Active-low chip select; high puts the device in standby |
| mem_oe_n | output | 1 | Active-low output gate |
| mem_dq | input | 16 | Data bus from the EPROM |

## Verification
The phase counter and the state register decide where both strobes fall and where the sample is taken. A miscount appears at the ports within one read as a strobe edge one cycle early or late. An early sample shows up as a wrong data word, because the bench memory model returns junk until every window it tracks has elapsed. A broken idle counter shows up within a few cycles of a finished read, as a chip-select rise that comes at the wrong time or never comes. A float window that is too short shows up as `req_ready` returning early, in the same read.

// File: rtl/eprom_rd_pkg.sv
`timescale 1ns/1ps
package eprom_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LEAD   = 2'd1,
    ST_STROBE = 2'd2,
    ST_FLOAT  = 2'd3
  } rd_state_e;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int ns, input int period);
    int r;
    r = (ns + period - 1) / period;
    if (r < 1) r = 1;
    return r;
  endfunction

endpackage

// File: rtl/eprom_rd_timer.sv
`timescale 1ns/1ps
module eprom_rd_timer #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/eprom_rd_park.sv
`timescale 1ns/1ps
module eprom_rd_park #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign expire = run && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (!expire) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/eprom_rd_capture.sv
`timescale 1ns/1ps
module eprom_rd_capture #(
  parameter int AW = 18,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_load,
  input  logic [AW-1:0] addr_in,
  input  logic          data_load,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] addr_out,
  output logic          word_valid,
  output logic [DW-1:0] word_out
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_out   <= '0;
      word_valid <= 1'b0;
      word_out   <= '0;
    end else begin
      word_valid <= data_load;
      if (addr_load) addr_out <= addr_in;
      if (data_load) word_out <= dq_in;
    end
  end

endmodule

// File: rtl/eprom_rd_ctrl.sv
`timescale 1ns/1ps
module eprom_rd_ctrl
  import eprom_rd_pkg::*;
#(
  parameter int AW            = 18,
  parameter int DW            = 16,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_ADDR_NS     = 70,
  parameter int T_CE_NS       = 70,
  parameter int T_OE_NS       = 35,
  parameter int T_FLOAT_NS    = 30,
  parameter int PARK_IDLE_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  input  logic [DW-1:0] mem_dq
);

  localparam int ADDR_CYC  = ns_to_cyc(T_ADDR_NS, CLK_PERIOD_NS);
  localparam int CE_CYC    = ns_to_cyc(T_CE_NS, CLK_PERIOD_NS);
  localparam int OE_CYC    = ns_to_cyc(T_OE_NS, CLK_PERIOD_NS);
  localparam int FLT_CYC   = ns_to_cyc(T_FLOAT_NS, CLK_PERIOD_NS);
  localparam int ACC_CYC   = (ADDR_CYC > CE_CYC) ? ADDR_CYC : CE_CYC;
  localparam int LEAD_CYC  = (ACC_CYC > OE_CYC) ? (ACC_CYC - OE_CYC) : 1;
  localparam int MAX_A     = (LEAD_CYC > OE_CYC) ? LEAD_CYC : OE_CYC;
  localparam int TMR_MAX   = (MAX_A > FLT_CYC) ? MAX_A : FLT_CYC;
  localparam int TMR_W     = $clog2(TMR_MAX + 1);
  localparam int PARK_LIM  = (PARK_IDLE_CYC < 1) ? 1 : PARK_IDLE_CYC;

  rd_state_e        state_q;
  logic             ce_n_q;
  logic             oe_n_q;
  logic             accept;
  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_done;
  logic             cap_load;
  logic             park_run;
  logic             park_expire;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign cap_load  = (state_q == ST_STROBE) && tmr_done;
  assign park_run  = (state_q == ST_IDLE) && !req_valid && !ce_n_q;
  assign mem_ce_n  = ce_n_q;
  assign mem_oe_n  = oe_n_q;

  // phase lengths loaded into the shared down-counter
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (accept) begin
      tmr_load = 1'b1;
      tmr_val  = TMR_W'(LEAD_CYC - 1);
    end else if (state_q == ST_LEAD && tmr_done) begin
      tmr_load = 1'b1;
      tmr_val  = TMR_W'(OE_CYC - 1);
    end else if (state_q == ST_STROBE && tmr_done) begin
      tmr_load = 1'b1;
      tmr_val  = TMR_W'(FLT_CYC - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            ce_n_q  <= 1'b0;
            state_q <= ST_LEAD;
          end else if (park_expire) begin
            ce_n_q  <= 1'b1;
          end
        end
        ST_LEAD: begin
          if (tmr_done) begin
            oe_n_q  <= 1'b0;
            state_q <= ST_STROBE;
          end
        end
        ST_STROBE: begin
          if (tmr_done) begin
            oe_n_q  <= 1'b1;
            state_q <= ST_FLOAT;
          end
        end
        ST_FLOAT: begin
          if (tmr_done) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  eprom_rd_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  eprom_rd_park #(.LIMIT(PARK_LIM)) u_park (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (park_run),
    .expire (park_expire)
  );

  eprom_rd_capture #(.AW(AW), .DW(DW)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_load  (accept),
    .addr_in    (req_addr),
    .data_load  (cap_load),
    .dq_in      (mem_dq),
    .addr_out   (mem_addr),
    .word_valid (rsp_valid),
    .word_out   (rsp_data)
  );

endmodule

// File: rtl/eprom_rd_ctrl_chk.sv
`timescale 1ns/1ps
module eprom_rd_ctrl_chk #(
  parameter int AW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_oe_n
);

  AST_GATE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_ce_n); // R3

  AST_BUSY_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> $stable(mem_addr)); // R2

  AST_ADDR_HELD_IN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> $stable(mem_addr)); // R6

  AST_RSP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R5

  AST_RSP_WITH_GATE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $rose(mem_oe_n)); // R5

  AST_FLOAT_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> !req_ready); // R7

  AST_PARK_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> (req_ready && mem_oe_n)); // R8

  AST_ACCEPT_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!mem_ce_n && !req_ready)); // R9

endmodule

bind eprom_rd_ctrl eprom_rd_ctrl_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n)
);

// File: tb/tb_eprom_rd_ctrl.sv
`timescale 1ns/1ps
module tb_eprom_rd_ctrl;

  localparam int B_ADDR = (70 + 9) / 10;
  localparam int B_CE   = (70 + 9) / 10;
  localparam int B_OE   = (35 + 9) / 10;
  localparam int B_FLT  = (30 + 9) / 10;
  localparam int B_ACC  = (B_ADDR > B_CE) ? B_ADDR : B_CE;
  localparam int B_LEAD = B_ACC - B_OE;
  localparam int B_PARK = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [17:0] req_addr = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic [17:0] mem_addr;
  logic        mem_ce_n;
  logic        mem_oe_n;
  wire  [15:0] mem_dq;

  int n_chk = 0;
  int n_err = 0;
  bit sim_done = 1'b0;

  always #5 clk = ~clk;

  eprom_rd_ctrl dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq    (mem_dq)
  );

  // EPROM model: junk until every access window has elapsed
  function automatic logic [15:0] word_of(input logic [17:0] a);
    return a[15:0] ^ {a[17:16], a[17:16], 12'h5A3};
  endfunction

  logic [17:0] m_last = '0;
  int m_a = 0, m_ce = 0, m_oe = 0;
  always @(negedge clk) begin
    m_a    <= (mem_addr != m_last) ? 1 : m_a + 1;
    m_last <= mem_addr;
    m_ce   <= mem_ce_n ? 0 : m_ce + 1;
    m_oe   <= mem_oe_n ? 0 : m_oe + 1;
  end
  wire m_ok = (m_a >= B_ADDR) && (m_ce >= B_CE) && (m_oe >= B_OE);
  assign mem_dq = (!mem_ce_n && !mem_oe_n) ? (m_ok ? word_of(mem_addr) : 16'hBAD0) : 16'hzzzz;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // one read; starts and returns at a negedge (return when ready is back)
  task automatic do_read(input logic [17:0] a, input bit intrude, input logic [17:0] ia,
                         input bit exp_parked);
    int oe_fall = 0, oe_rise = 0, rsp_n = 0, rsp_at = 0, rdy_at = 0;
    logic [15:0] word = '0;
    bit addr_ok = 1'b1, ce_ok = 1'b1;
    check(req_ready == 1'b1, "R2 ready before request", req_ready, 1);
    check(mem_ce_n == exp_parked, exp_parked ? "R9 parked before request" : "R10 select kept low",
          mem_ce_n, exp_parked);
    req_valid = 1'b1;
    req_addr  = a;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (i == 1) req_valid = 1'b0;
      if (intrude && i == 2) begin req_valid = 1'b1; req_addr = ia; end
      if (intrude && i == 4) req_valid = 1'b0;
      if (i <= B_ACC + 1 && mem_addr != a) addr_ok = 1'b0;
      if (i <= B_ACC && mem_ce_n) ce_ok = 1'b0;
      if (!mem_oe_n && oe_fall == 0) oe_fall = i;
      if (mem_oe_n && oe_fall != 0 && oe_rise == 0) oe_rise = i;
      if (rsp_valid) begin rsp_n++; rsp_at = i; word = rsp_data; end
      if (req_ready) begin rdy_at = i; break; end
    end
    check(oe_fall == B_LEAD + 1, "R4 gate fall cycle", oe_fall, B_LEAD + 1);
    check(rsp_n == 1 && rsp_at == B_ACC + 1, "R5 response pulse cycle", rsp_at, B_ACC + 1);
    check(word == word_of(a), "R5 response word", word, word_of(a));
    check(oe_rise == B_ACC + 1, "R5 gate rise cycle", oe_rise, B_ACC + 1);
    check(addr_ok, intrude ? "R2 busy request ignored" : "R6 address held", mem_addr, a);
    check(ce_ok, "R9 select low during read", ce_ok, 1);
    check(rdy_at == B_ACC + B_FLT + 1, "R7 float turnaround", rdy_at, B_ACC + B_FLT + 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_oe_n && !rsp_valid && req_ready, "R1 state in reset",
          {mem_ce_n, mem_oe_n, rsp_valid, req_ready}, 4'b1101);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_ce_n && mem_oe_n && !rsp_valid && req_ready, "R1 state after reset",
          {mem_ce_n, mem_oe_n, rsp_valid, req_ready}, 4'b1101);
  endtask

  task automatic t_park();
    // ready already seen in idle cycle 1
    for (int j = 1; j < B_PARK; j++) begin
      @(negedge clk);
      check(!mem_ce_n, "R8 select low before idle limit", mem_ce_n, 0);
    end
    @(negedge clk);
    check(mem_ce_n && mem_oe_n, "R8 standby after idle limit", mem_ce_n, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!sim_done) begin
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_sim();
    end
  end

  initial begin
    t_reset();
    do_read(18'h00000, 1'b0, '0, 1'b1);          // R9 wake from reset standby
    do_read(18'h3FFFF, 1'b0, '0, 1'b0);          // R10 chained, top address
    do_read(18'h12345, 1'b1, 18'h2AAAA, 1'b0);   // R2 intrusion while busy
    t_park();
    do_read(18'h0F0F1, 1'b0, '0, 1'b1);          // R9 after idle standby
    do_read(18'h20001, 1'b0, '0, 1'b0);          // R10 back-to-back
    t_park();
    sim_done = 1'b1;
    finish_sim();
  end

endmodule